// File: doc/BRIEF.md
# Command Ring Network Node

This block is one stop on a unidirectional ring that joins a central controller to a set of peripheral modules. Every stop carries 8-bit flits on a circuit-switched path with no per-hop packet storage. The same node serves either end of the ring. The `master_mode` pin selects the role, and it is held steady from reset onward. A change of role needs a new reset.

In master mode the node originates all traffic. It sends a round of packets. Each packet is one header flit and a fixed number of payload flits. A packet slot carries a command when the controller offers one as the slot opens; otherwise the slot goes out as an empty packet. The master absorbs the returning stream. It hands every packet that a slave filled to the controller, tagged with the sender's id. It starts the next round only after the whole previous round has come back.

In slave mode the node forwards each flit with one cycle of delay. It takes a command packet that carries its own id, delivers the payload locally, and lets an empty packet continue in its place. When the local module offers a result, the node writes it into the first free empty packet that passes.

Header layout: bit 7 is the type (1 = command, 0 = empty). Bits 6:4 are the node id: the destination for a command, the source for a filled packet. Bit 3 is the filled flag. Bits 2:0 are reserved, zero from the master and forwarded as they arrive. A free empty packet has bit 7 = 0 and bit 3 = 0.

Local interfaces:
- The local input (`loc_in_*`) is valid/ready. `loc_in_vld` must stay high with `loc_in_dat` and `loc_in_id` stable until the cycle in which `loc_in_rdy` is also high. That cycle is the transfer.
- The local output (`loc_out_*`) is a one-cycle valid pulse with no back-pressure. A circuit-switched ring cannot stall, so the receiver must accept every pulse.
- Payload bytes travel most significant byte first.

Top module: `cmd_ring_node`

## Requirements
- R1: While reset is held and in the first cycle after its release with no ring input, `ring_out_vld` and `loc_out_vld` are low in slave mode.
- R2: In slave mode every flit that is not consumed or replaced leaves on `ring_out_dat` unchanged, exactly one cycle after it was sampled; no input flit means no output flit.
- R3: A slave that sees a command header (bit 7 = 1) with bits 6:4 equal to `node_id` sends header 0x00 and zero payload flits in place of that packet. It raises `loc_out_vld` for exactly one cycle in the same cycle as the last replaced flit, with `loc_out_dat` holding the three payload bytes (first flit in bits 23:16) and `loc_out_id` equal to `node_id`.
- R4: A command header whose id differs from `node_id` passes the whole packet through unchanged and produces no `loc_out_vld`.
- R5: In slave mode `loc_in_rdy` is high only while a free empty header (bit 7 = 0, bit 3 = 0) is on the ring input. On transfer the packet leaves with header {0, node_id, 1, 000} and payload bytes from `loc_in_dat`, bits 23:16 first.
- R6: A slave with a pending result passes filled empty packets and command packets for other nodes unchanged, and fills the next free empty packet. A slave with no pending result passes a free empty packet unchanged.
- R7: In master mode the node emits a round of 4 packets, 16 flits on 16 consecutive cycles, the first flit appearing in the cycle after the first clock edge that follows reset release.
- R8: At each master packet slot, a pending command is accepted (`loc_in_rdy` high in the header cycle) and sent as header {1, loc_in_id, 0000} followed by its bytes, bits 23:16 first. With no command the slot is four 0x00 flits.
- R9: After a round the master emits nothing until 16 flits have returned on the ring input. The next round's header appears one cycle after the cycle in which the 16th returning flit is seen on the output side.
- R10: For each returning packet with bit 7 = 0 and bit 3 = 1, the master pulses `loc_out_vld` once, in the cycle after the packet's last flit is sampled, with `loc_out_id` = header bits 6:4 and the payload. Returning free empty packets and command packets produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_mode | input | 1 | 1 = controller end of the ring, 0 = peripheral stop |
| node_id | input | 3 | Own id in slave mode |
| ring_in_vld | input | 1 | Flit present on ring input |
| ring_in_dat | input | 8 | Ring input flit |
| ring_out_vld | output | 1 | Flit present on ring output |
| ring_out_dat | output | 8 | Ring output flit |
| loc_in_vld | input | 1 | Local offer: result (slave) or command (master) |
| loc_in_rdy | output | 1 | Local offer accepted this cycle |
| loc_in_id | input | 3 | Command destination (master only) |
| loc_in_dat | input | 24 | Local offer payload |
| loc_out_vld | output | 1 | One-cycle delivery pulse |
| loc_out_id | output | 3 | Own id (slave) or result source (master) |
| loc_out_dat | output | 24 | Delivered payload |

## Verification
The bench builds the node with its defaults: three payload flits per packet and four packets per round. A full round is therefore 16 flits, and one short directed sequence covers both the round boundary and the wait for the round's return. Driving the ring input directly lets the bench place a matching command, a foreign command, a filled packet and a free empty packet in any order. That exposes the slave's first-free-slot selection. With both roles on one instance, the master's slot acceptance and its filtering of returning packets are checked against the same header encoding.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;
  localparam int FLIT_W   = 8;
  localparam int ID_W     = 3;
  localparam int TYPE_BIT = 7;
  localparam int ID_LSB   = 4;
  localparam int FILL_BIT = 3;

  typedef logic [FLIT_W-1:0] flit_t;
  typedef logic [ID_W-1:0]   nid_t;

  function automatic flit_t hdr_cmd(nid_t id);
    flit_t f = '0;
    f[TYPE_BIT] = 1'b1;
    f[ID_LSB +: ID_W] = id;
    return f;
  endfunction

  function automatic flit_t hdr_filled(nid_t id);
    flit_t f = '0;
    f[ID_LSB +: ID_W] = id;
    f[FILL_BIT] = 1'b1;
    return f;
  endfunction

  function automatic logic is_cmd(flit_t f);
    return f[TYPE_BIT];
  endfunction

  function automatic logic is_free(flit_t f);
    return !f[TYPE_BIT] && !f[FILL_BIT];
  endfunction

  function automatic logic is_filled(flit_t f);
    return !f[TYPE_BIT] && f[FILL_BIT];
  endfunction

  function automatic nid_t hdr_id(flit_t f);
    return f[ID_LSB +: ID_W];
  endfunction
endpackage

// File: rtl/cmd_ring_flit_ctr.sv
module cmd_ring_flit_ctr #(
  parameter int PKT_LEN = 4,
  parameter int PKTS    = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         step,
  output logic [$clog2(PKT_LEN)-1:0]   pos,
  output logic                         round_end
);
  localparam int PW = $clog2(PKT_LEN);
  localparam int KW = (PKTS > 1) ? $clog2(PKTS) : 1;

  logic [KW-1:0] pkt;
  logic          pkt_end;

  assign pkt_end   = (pos == PW'(PKT_LEN - 1));
  assign round_end = pkt_end && (pkt == KW'(PKTS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= '0;
      pkt <= '0;
    end else if (step) begin
      pos <= pkt_end ? '0 : pos + 1'b1;
      if (pkt_end) pkt <= (pkt == KW'(PKTS - 1)) ? '0 : pkt + 1'b1;
    end
  end
endmodule

// File: rtl/cmd_ring_slave.sv
module cmd_ring_slave
  import cmd_ring_pkg::*;
#(
  parameter int PAY_FLITS = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  nid_t                          node_id,
  input  logic                          in_vld,
  input  flit_t                         in_dat,
  output logic                          out_vld,
  output flit_t                         out_dat,
  input  logic                          res_vld,
  output logic                          res_rdy,
  input  logic [PAY_FLITS*FLIT_W-1:0]   res_dat,
  output logic                          cmd_vld,
  output logic [PAY_FLITS*FLIT_W-1:0]   cmd_dat
);
  localparam int PKT_LEN = PAY_FLITS + 1;
  localparam int PW      = $clog2(PKT_LEN);
  localparam int PAY_W   = PAY_FLITS * FLIT_W;
  localparam int CAP_W   = PAY_W - FLIT_W;

  typedef enum logic [1:0] {S_PASS, S_TAKE, S_FILL} smode_t;

  logic [PW-1:0]    pos;
  smode_t           mode;
  logic [CAP_W-1:0] cap;
  logic [PAY_W-1:0] fill_sr;
  logic             at_hdr, at_last, hit;

  assign at_hdr  = (pos == '0);
  assign at_last = (pos == PW'(PKT_LEN - 1));
  assign hit     = is_cmd(in_dat) && (hdr_id(in_dat) == node_id);
  assign res_rdy = in_vld && at_hdr && is_free(in_dat);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos     <= '0;
      mode    <= S_PASS;
      cap     <= '0;
      fill_sr <= '0;
      out_vld <= 1'b0;
      out_dat <= '0;
      cmd_vld <= 1'b0;
      cmd_dat <= '0;
    end else begin
      out_vld <= in_vld;
      cmd_vld <= 1'b0;
      if (in_vld) begin
        pos <= at_last ? '0 : pos + 1'b1;
        if (at_hdr) begin
          if (hit) begin
            mode    <= S_TAKE;
            out_dat <= '0;
          end else if (res_rdy && res_vld) begin
            mode    <= S_FILL;
            fill_sr <= res_dat;
            out_dat <= hdr_filled(node_id);
          end else begin
            mode    <= S_PASS;
            out_dat <= in_dat;
          end
        end else begin
          unique case (mode)
            S_TAKE: begin
              out_dat <= '0;
              cap     <= {cap[CAP_W-FLIT_W-1:0], in_dat};
              if (at_last) begin
                cmd_vld <= 1'b1;
                cmd_dat <= {cap, in_dat};
              end
            end
            S_FILL: begin
              out_dat <= fill_sr[PAY_W-1 -: FLIT_W];
              fill_sr <= fill_sr << FLIT_W;
            end
            default: out_dat <= in_dat;
          endcase
        end
      end
    end
  end

  assert_fwd_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);
  assert_take_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |=> !cmd_vld);
  assert_fill_hdr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_rdy) |=> (out_vld && is_filled(out_dat) && hdr_id(out_dat) == node_id));
endmodule

// File: rtl/cmd_ring_master.sv
module cmd_ring_master
  import cmd_ring_pkg::*;
#(
  parameter int PAY_FLITS = 3,
  parameter int PKTS      = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en,
  input  logic                          in_vld,
  input  flit_t                         in_dat,
  output logic                          out_vld,
  output flit_t                         out_dat,
  input  logic                          cmd_vld,
  output logic                          cmd_rdy,
  input  nid_t                          cmd_id,
  input  logic [PAY_FLITS*FLIT_W-1:0]   cmd_dat,
  output logic                          res_vld,
  output nid_t                          res_id,
  output logic [PAY_FLITS*FLIT_W-1:0]   res_dat
);
  localparam int PKT_LEN = PAY_FLITS + 1;
  localparam int PW      = $clog2(PKT_LEN);
  localparam int PAY_W   = PAY_FLITS * FLIT_W;
  localparam int CAP_W   = PAY_W - FLIT_W;

  logic             active;
  logic             tx_step, rx_step, tx_end, rx_end;
  logic [PW-1:0]    tx_pos, rx_pos;
  logic [PAY_W-1:0] tx_sr;
  logic [CAP_W-1:0] rx_cap;
  logic             rx_keep;
  nid_t             rx_src;

  assign tx_step = en && active;
  assign rx_step = en && in_vld;
  assign cmd_rdy = tx_step && (tx_pos == '0);

  cmd_ring_flit_ctr #(.PKT_LEN(PKT_LEN), .PKTS(PKTS)) u_tx_ctr (
    .clk(clk), .rst_n(rst_n), .step(tx_step), .pos(tx_pos), .round_end(tx_end));

  cmd_ring_flit_ctr #(.PKT_LEN(PKT_LEN), .PKTS(PKTS)) u_rx_ctr (
    .clk(clk), .rst_n(rst_n), .step(rx_step), .pos(rx_pos), .round_end(rx_end));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b1;
      out_vld <= 1'b0;
      out_dat <= '0;
      tx_sr   <= '0;
      rx_cap  <= '0;
      rx_keep <= 1'b0;
      rx_src  <= '0;
      res_vld <= 1'b0;
      res_id  <= '0;
      res_dat <= '0;
    end else begin
      out_vld <= 1'b0;
      res_vld <= 1'b0;
      if (tx_step) begin
        out_vld <= 1'b1;
        if (tx_pos == '0) begin
          out_dat <= cmd_vld ? hdr_cmd(cmd_id) : '0;
          tx_sr   <= cmd_vld ? cmd_dat : '0;
        end else begin
          out_dat <= tx_sr[PAY_W-1 -: FLIT_W];
          tx_sr   <= tx_sr << FLIT_W;
        end
        if (tx_end) active <= 1'b0;
      end
      if (rx_step) begin
        if (rx_pos == '0) begin
          rx_keep <= is_filled(in_dat);
          rx_src  <= hdr_id(in_dat);
        end else begin
          rx_cap <= {rx_cap[CAP_W-FLIT_W-1:0], in_dat};
          if (rx_pos == PW'(PKT_LEN - 1) && rx_keep) begin
            res_vld <= 1'b1;
            res_id  <= rx_src;
            res_dat <= {rx_cap, in_dat};
          end
        end
        if (rx_end) active <= 1'b1;
      end
    end
  end

  assert_hdr_on_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_rdy) |=> (out_vld && is_cmd(out_dat)));
  assert_result_from_ring_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> $past(in_vld));
endmodule

// File: rtl/cmd_ring_node.sv
module cmd_ring_node
  import cmd_ring_pkg::*;
#(
  parameter int PAY_FLITS      = 3,
  parameter int PKTS_PER_ROUND = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          master_mode,
  input  logic [ID_W-1:0]               node_id,
  input  logic                          ring_in_vld,
  input  logic [FLIT_W-1:0]             ring_in_dat,
  output logic                          ring_out_vld,
  output logic [FLIT_W-1:0]             ring_out_dat,
  input  logic                          loc_in_vld,
  output logic                          loc_in_rdy,
  input  logic [ID_W-1:0]               loc_in_id,
  input  logic [PAY_FLITS*FLIT_W-1:0]   loc_in_dat,
  output logic                          loc_out_vld,
  output logic [ID_W-1:0]               loc_out_id,
  output logic [PAY_FLITS*FLIT_W-1:0]   loc_out_dat
);
  localparam int PAY_W = PAY_FLITS * FLIT_W;

  logic             s_out_vld, m_out_vld, s_rdy, m_rdy, s_del_vld, m_del_vld;
  flit_t            s_out_dat, m_out_dat;
  nid_t             m_del_id;
  logic [PAY_W-1:0] s_del_dat, m_del_dat;

  cmd_ring_slave #(.PAY_FLITS(PAY_FLITS)) u_slave (
    .clk(clk), .rst_n(rst_n), .node_id(node_id),
    .in_vld(ring_in_vld && !master_mode), .in_dat(ring_in_dat),
    .out_vld(s_out_vld), .out_dat(s_out_dat),
    .res_vld(loc_in_vld && !master_mode), .res_rdy(s_rdy), .res_dat(loc_in_dat),
    .cmd_vld(s_del_vld), .cmd_dat(s_del_dat));

  cmd_ring_master #(.PAY_FLITS(PAY_FLITS), .PKTS(PKTS_PER_ROUND)) u_master (
    .clk(clk), .rst_n(rst_n), .en(master_mode),
    .in_vld(ring_in_vld), .in_dat(ring_in_dat),
    .out_vld(m_out_vld), .out_dat(m_out_dat),
    .cmd_vld(loc_in_vld), .cmd_rdy(m_rdy), .cmd_id(loc_in_id), .cmd_dat(loc_in_dat),
    .res_vld(m_del_vld), .res_id(m_del_id), .res_dat(m_del_dat));

  always_comb begin
    if (master_mode) begin
      ring_out_vld = m_out_vld;
      ring_out_dat = m_out_dat;
      loc_in_rdy   = m_rdy;
      loc_out_vld  = m_del_vld;
      loc_out_id   = m_del_id;
      loc_out_dat  = m_del_dat;
    end else begin
      ring_out_vld = s_out_vld;
      ring_out_dat = s_out_dat;
      loc_in_rdy   = s_rdy;
      loc_out_vld  = s_del_vld;
      loc_out_id   = node_id;
      loc_out_dat  = s_del_dat;
    end
  end
endmodule

// File: tb/sim_cmd_ring_node.sv
module sim_cmd_ring_node;
  logic        clk = 1'b0;
  logic        rst_n, master_mode;
  logic [2:0]  node_id, loc_in_id, loc_out_id;
  logic        ring_in_vld, ring_out_vld, loc_in_vld, loc_in_rdy, loc_out_vld;
  logic [7:0]  ring_in_dat, ring_out_dat;
  logic [23:0] loc_in_dat, loc_out_dat;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  cmd_ring_node u0 (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .node_id(node_id),
    .ring_in_vld(ring_in_vld), .ring_in_dat(ring_in_dat),
    .ring_out_vld(ring_out_vld), .ring_out_dat(ring_out_dat),
    .loc_in_vld(loc_in_vld), .loc_in_rdy(loc_in_rdy), .loc_in_id(loc_in_id),
    .loc_in_dat(loc_in_dat), .loc_out_vld(loc_out_vld), .loc_out_id(loc_out_id),
    .loc_out_dat(loc_out_dat));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic mode);
    rst_n = 1'b0; master_mode = mode; ring_in_vld = 1'b0; ring_in_dat = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drive one flit before the edge, sample just after it
  task automatic push(input logic [7:0] d);
    @(negedge clk);
    ring_in_vld = 1'b1; ring_in_dat = d;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    @(negedge clk);
    ring_in_vld = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    loc_in_vld = 1'b0; node_id = 3'd2;
    rst_n = 1'b0; master_mode = 1'b0; ring_in_vld = 1'b0; ring_in_dat = '0;
    repeat (2) @(posedge clk); #1;
    chk("R1 ring_out_vld in reset", ring_out_vld, 0);
    chk("R1 loc_out_vld in reset", loc_out_vld, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 ring_out_vld after reset", ring_out_vld, 0);
  endtask

  task automatic t_forward();
    logic [7:0] p [4] = '{8'hD0, 8'hAA, 8'hBB, 8'hCC};
    for (int i = 0; i < 4; i++) begin
      push(p[i]);
      chk("R4 foreign cmd flit forwarded", {ring_out_vld, ring_out_dat}, {1'b1, p[i]});
      chk("R4 no delivery", loc_out_vld, 0);
    end
    idle();
    chk("R2 no input no output", ring_out_vld, 0);
  endtask

  task automatic t_consume();
    logic [7:0] p [4] = '{8'hA5, 8'h11, 8'h22, 8'h33};
    for (int i = 0; i < 4; i++) begin
      push(p[i]);
      chk("R3 consumed flit replaced by zero", {ring_out_vld, ring_out_dat}, 9'h100);
      if (i < 3) chk("R3 no early delivery", loc_out_vld, 0);
    end
    chk("R3 delivery pulse", loc_out_vld, 1);
    chk("R3 delivery data", loc_out_dat, 24'h112233);
    chk("R3 delivery id", loc_out_id, 2);
    idle();
    chk("R3 pulse is one cycle", loc_out_vld, 0);
  endtask

  task automatic t_fill();
    @(negedge clk);
    loc_in_vld = 1'b1; loc_in_dat = 24'hDEADBE;
    ring_in_vld = 1'b0;
    #1 chk("R5 rdy low without free header", loc_in_rdy, 0);
    // filled packet from another node passes
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      ring_in_vld = 1'b1; ring_in_dat = (i == 0) ? 8'h58 : 8'(i);
      #1 if (i == 0) chk("R6 rdy low on filled header", loc_in_rdy, 0);
      @(posedge clk); #1;
      chk("R6 filled packet unchanged", ring_out_dat, (i == 0) ? 32'h58 : i);
    end
    // foreign command passes
    push(8'hF0); chk("R6 foreign cmd header unchanged", ring_out_dat, 8'hF0);
    push(8'h01); push(8'h02); push(8'h03);
    chk("R6 foreign cmd payload unchanged", ring_out_dat, 8'h03);
    // first free empty gets the result
    @(negedge clk);
    ring_in_vld = 1'b1; ring_in_dat = 8'h00;
    #1 chk("R5 rdy on free header", loc_in_rdy, 1);
    @(posedge clk); #1;
    chk("R5 filled header", {ring_out_vld, ring_out_dat}, 9'h128);
    @(negedge clk); loc_in_vld = 1'b0;
    @(posedge clk); #1; chk("R5 byte 0", ring_out_dat, 8'hDE);
    push(8'h00); chk("R5 byte 1", ring_out_dat, 8'hAD);
    push(8'h00); chk("R5 byte 2", ring_out_dat, 8'hBE);
    // no pending result: empty passes
    push(8'h00); chk("R6 empty header unchanged", ring_out_dat, 8'h00);
    push(8'h00); push(8'h00); push(8'h07);
    chk("R6 empty payload unchanged", ring_out_dat, 8'h07);
    idle();
  endtask

  task automatic t_master_tx();
    loc_in_vld = 1'b1; loc_in_id = 3'd3; loc_in_dat = 24'h0A0B0C;
    do_reset(1'b1);
    @(posedge clk); #1;
    chk("R7 round starts after reset", ring_out_vld, 1);
    chk("R8 cmd header", ring_out_dat, 8'hB0);
    @(negedge clk); loc_in_vld = 1'b0;
    for (int i = 1; i < 16; i++) begin
      @(posedge clk); #1;
      chk("R7 consecutive flits", ring_out_vld, 1);
      case (i)
        1: chk("R8 cmd byte 0", ring_out_dat, 8'h0A);
        2: chk("R8 cmd byte 1", ring_out_dat, 8'h0B);
        3: chk("R8 cmd byte 2", ring_out_dat, 8'h0C);
        default: chk("R8 empty slot flit", ring_out_dat, 8'h00);
      endcase
    end
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      chk("R9 silent until round returns", ring_out_vld, 0);
    end
  endtask

  task automatic t_master_rx();
    logic [7:0] r [16] = '{8'h48, 8'h77, 8'h88, 8'h99,
                           8'hB0, 8'h0A, 8'h0B, 8'h0C,
                           8'h00, 8'h00, 8'h00, 8'h00,
                           8'h18, 8'h01, 8'h02, 8'h03};
    for (int i = 0; i < 16; i++) begin
      push(r[i]);
      if (i == 3) begin
        chk("R10 result from node 4", loc_out_vld, 1);
        chk("R10 source id", loc_out_id, 4);
        chk("R10 payload", loc_out_dat, 24'h778899);
      end else if (i == 15) begin
        chk("R10 result from node 1", loc_out_vld, 1);
        chk("R10 source id", loc_out_id, 1);
        chk("R10 payload", loc_out_dat, 24'h010203);
      end else if (i == 7 || i == 11) begin
        chk("R10 no delivery for cmd or free empty", loc_out_vld, 0);
      end
      chk("R9 no output while round returns", ring_out_vld, 0);
    end
    idle();
    chk("R9 next round header", {ring_out_vld, ring_out_dat}, 9'h100);
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    loc_in_id = '0; loc_in_dat = '0;
    t_reset();
    t_forward();
    t_consume();
    t_fill();
    t_master_tx();
    t_master_rx();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule